// File: doc/BRIEF.md
# I2C Bus Time-out Detector

This block watches an already synchronised I2C bus and reports two kinds of stall. The first, the event watchdog, measures the time since the last bus event. A bus event is an SCL edge, a Start or a Stop. This watchdog is held quiet while the bus is not active. The second, the clock-low watchdog, measures how long SCL has stayed low. Both watchdogs compare against one programmable threshold. They count ticks of a shared pre-divider, which divides the function clock.

Each watchdog sets a sticky flag once each time its interval expires. Software clears a flag by writing 1 to its clear strobe. Each flag has its own interrupt enable, and the enabled flags are ORed into one interrupt line. Clearing the enable input holds the counters and the pre-divider in reset. The flags keep their values while the block is disabled.

Top module: `i2c_timeout_watch`

## Requirements
- R1: After a synchronous active-low reset, both flags, both interrupt enables and the interrupt output are 0.
- R2: The pre-divider issues one tick every DIV+1 function clocks, where DIV is the 16-bit divider value. The threshold is (TO+1)*16 ticks, where TO is the 12-bit time-out value. From the clock edge at which the block becomes enabled, a watchdog that runs without a restart sets its flag on edge number (DIV+1)*(TO+1)*16.
- R3: The time-out readback port returns TO in bits 15:4 and the constant 0xF in bits 3:0.
- R4: While the bus-active input is 1, the event flag (interrupt source 0) is set when the threshold number of ticks passes with no bus event. An SCL edge, a Start (SDA falls while SCL stays high) or a Stop (SDA rises while SCL stays high) restarts the count. The count restarts on the edge where the event is seen.
- R5: While the bus-active input is 0, the event watchdog is held at zero and never sets its flag.
- R6: The clock-low flag (interrupt source 1) is set when SCL has been low for the threshold number of ticks. The first tick is the edge at which SCL is first seen low. SCL high holds this watchdog at zero.
- R7: Each flag stays set until a 1 is written to its clear strobe. If an expiry and a clear fall in the same cycle, the flag stays set.
- R8: A watchdog sets its flag only once per expiry. After a clear it does not set the flag again until its count has restarted and the full threshold has passed again.
- R9: While the enable input is 0, both watchdogs and the pre-divider are held at zero, so no flag can be set. Flags that are already set keep their values.
- R10: The interrupt output is 1 exactly when some flag is set and its enable is set. The enables use write-1-to-set and write-1-to-clear strobes, and a clear wins over a set in the same cycle. Bit 0 of every 2-bit vector belongs to the event watchdog and bit 1 to the clock-low watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| bus_busy_i | input | 1 | 1 while a master owns the bus (Start seen more recently than Stop) |
| to_en_i | input | 1 | Time-out function enable |
| div_val_i | input | 16 | Pre-divider value; tick period is div_val_i+1 clocks |
| to_val_i | input | 12 | Time-out value; threshold is (to_val_i+1)*16 ticks |
| ie_set_i | input | 2 | Write-1-to-set strobes for the interrupt enables |
| ie_clr_i | input | 2 | Write-1-to-clear strobes for the interrupt enables |
| flag_clr_i | input | 2 | Write-1-to-clear strobes for the flags |
| timeout_rb_o | output | 16 | Time-out readback with the low nibble fixed to 0xF |
| evt_flag_o | output | 1 | Sticky event time-out flag |
| scl_flag_o | output | 1 | Sticky SCL-low time-out flag |
| irq_o | output | 1 | Combined interrupt of the enabled flags |

## Verification
A software clear strobe on a flag can land in the same cycle as that flag's expiry. The bench provokes this by holding SCL low and raising the clock-low clear strobe for exactly the cycle of the expiry edge. The flag must then read 1, and a later clear on its own must bring it to 0. In the same way, an enable set strobe and an enable clear strobe on the same bit are given in one cycle. The bench judges the result at the interrupt output, which must stay 0.

// File: rtl/i2c_to_pkg.sv
// Package: shared constants for the I2C bus time-out detector.
// Assumes two watchdogs whose index also selects the bit in every
// strobe vector of the top module.
package i2c_to_pkg;
    localparam int NUM_WD     = 2;  // number of watchdogs
    localparam int WD_EVENT   = 0;  // bus-event gap watchdog index
    localparam int WD_SCL_LOW = 1;  // SCL-low watchdog index
    localparam int RES_BITS   = 4;  // threshold resolution bits (x16)
endpackage

// File: rtl/i2c_to_prediv.sv
// Module: clock pre-divider. Produces a one-cycle tick every div_i+1
// clocks. Assumes that a disabled block must restart with a known phase,
// so the counter is held at zero while en_i is low.
module i2c_to_prediv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Purpose: count 0..div_i and wrap; held at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == div_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: tick on the last count of each period.
    always_comb begin
        tick_o = en_i && (cnt_q == div_i);
    end
endmodule

// File: rtl/i2c_to_bus_events.sv
// Module: bus event detector. Flags an SCL edge, a Start or a Stop in the
// cycle it is first visible. Assumes scl_i/sda_i are already synchronised;
// the idle bus level (both high) is assumed out of reset.
module i2c_to_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic event_o
);
    logic scl_q, sda_q;
    logic scl_edge, start_seen, stop_seen;

    // Purpose: keep the previous bus levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Purpose: classify the current cycle as an event or not.
    always_comb begin
        scl_edge   = scl_i ^ scl_q;
        start_seen = scl_i && scl_q && sda_q && !sda_i;
        stop_seen  = scl_i && scl_q && !sda_q && sda_i;
        event_o    = scl_edge || start_seen || stop_seen;
    end
endmodule

// File: rtl/i2c_to_watchdog.sv
// Module: one saturating watchdog counter. Counts ticks from zero,
// restarting whenever restart_i is high. expire_o pulses on the tick that
// brings the count to limit_i; the count then holds until a restart, so
// there is one pulse per expiry. Assumes limit_i >= 1.
module i2c_to_watchdog #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: count ticks up to the limit, restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != limit_i)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: single-cycle expiry pulse on the tick reaching the limit.
    always_comb begin
        expire_o = !restart_i && tick_i && (cnt_q == (limit_i - 1'b1));
    end
endmodule

// File: rtl/i2c_timeout_watch.sv
// Module: I2C bus time-out detector top. A shared pre-divider feeds two
// watchdogs: a bus-event gap watchdog (quiet while the bus is idle) and
// an SCL-low watchdog. Their expiries set sticky write-1-to-clear flags,
// combined with per-flag enables into one interrupt. Assumes synchronised
// bus inputs and that the settings are changed only while disabled.
module i2c_timeout_watch
    import i2c_to_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TO_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              bus_busy_i,
    input  logic              to_en_i,
    input  logic [DIV_W-1:0]  div_val_i,
    input  logic [TO_W-1:0]   to_val_i,
    input  logic [NUM_WD-1:0] ie_set_i,
    input  logic [NUM_WD-1:0] ie_clr_i,
    input  logic [NUM_WD-1:0] flag_clr_i,
    output logic [TO_W+RES_BITS-1:0] timeout_rb_o,
    output logic              evt_flag_o,
    output logic              scl_flag_o,
    output logic              irq_o
);
    localparam int CNT_W = TO_W + RES_BITS + 1;

    logic              tick;
    logic              bus_event;
    logic [CNT_W-1:0]  limit;
    logic [NUM_WD-1:0] restart;
    logic [NUM_WD-1:0] expire;
    logic [NUM_WD-1:0] flags_q;
    logic [NUM_WD-1:0] ie_q;

    i2c_to_prediv #(.DIV_W(DIV_W)) u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (to_en_i),
        .div_i  (div_val_i),
        .tick_o (tick)
    );

    i2c_to_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .event_o (bus_event)
    );

    // Purpose: threshold (TO+1)*16 ticks and the readback value.
    always_comb begin
        limit        = {1'b0, to_val_i, {RES_BITS{1'b1}}} + CNT_W'(1);
        timeout_rb_o = {to_val_i, {RES_BITS{1'b1}}};
    end

    // Purpose: restart conditions of each watchdog.
    always_comb begin
        restart[WD_EVENT]   = !to_en_i || !bus_busy_i || bus_event;
        restart[WD_SCL_LOW] = !to_en_i || scl_i;
    end

    for (genvar g = 0; g < NUM_WD; g++) begin : g_wd
        i2c_to_watchdog #(.CNT_W(CNT_W)) u_wd (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart[g]),
            .tick_i    (tick),
            .limit_i   (limit),
            .expire_o  (expire[g])
        );
    end

    // Purpose: sticky flags, write-1-to-clear, an expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr_i) | expire;
        end
    end

    // Purpose: interrupt enables with set/clear strobes, a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else begin
            ie_q <= (ie_q | ie_set_i) & ~ie_clr_i;
        end
    end

    // Purpose: drive the flag and interrupt outputs.
    always_comb begin
        evt_flag_o = flags_q[WD_EVENT];
        scl_flag_o = flags_q[WD_SCL_LOW];
        irq_o      = |(flags_q & ie_q);
    end
endmodule

// File: rtl/i2c_timeout_watch_chk.sv
// Module: property checker for the time-out detector, attached by bind.
// Assumes the port meanings of the top module.
module i2c_timeout_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       bus_busy_i,
    input logic       to_en_i,
    input logic [1:0] flag_clr_i,
    input logic       evt_flag_o,
    input logic       scl_flag_o,
    input logic       irq_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!evt_flag_o && !scl_flag_o && !irq_o));

    assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag_o && !flag_clr_i[0]) |=> evt_flag_o);

    assert_scl_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_flag_o && !flag_clr_i[1]) |=> scl_flag_o);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy_i && !evt_flag_o) |=> !evt_flag_o);

    assert_scl_high_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && !scl_flag_o) |=> !scl_flag_o);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_en_i && !evt_flag_o && !scl_flag_o) |=> (!evt_flag_o && !scl_flag_o));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_flag_o && !scl_flag_o) |-> !irq_o);
endmodule

bind i2c_timeout_watch i2c_timeout_watch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .bus_busy_i (bus_busy_i),
    .to_en_i    (to_en_i),
    .flag_clr_i (flag_clr_i),
    .evt_flag_o (evt_flag_o),
    .scl_flag_o (scl_flag_o),
    .irq_o      (irq_o)
);

// File: tb/i2c_timeout_watch_tb.sv
// Directed bench for the I2C bus time-out detector. Inputs change 2 time
// units after a rising edge; outputs are sampled at the same point.
module i2c_timeout_watch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl, sda, busy, en;
    logic [15:0] div_val;
    logic [11:0] to_val;
    logic [1:0]  ie_set, ie_clr, flag_clr;
    logic [15:0] rb;
    logic        evt_flag, scl_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    i2c_timeout_watch u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .bus_busy_i(busy), .to_en_i(en), .div_val_i(div_val),
        .to_val_i(to_val), .ie_set_i(ie_set), .ie_clr_i(ie_clr),
        .flag_clr_i(flag_clr), .timeout_rb_o(rb), .evt_flag_o(evt_flag),
        .scl_flag_o(scl_flag), .irq_o(irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        scl = 1; sda = 1; busy = 0; en = 1; div_val = 0; to_val = 0;
        ie_set = 0; ie_clr = 0; flag_clr = 0;
        rst_n = 0;
        step(2);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 evt flag", evt_flag, 0);
        chk("R1 scl flag", scl_flag, 0);
        chk("R1 irq", irq, 0);
        busy = 1;
        step(16);
        chk("R1 flag raised", evt_flag, 1);
        chk("R1 enables reset, irq", irq, 0);
    endtask

    task automatic t_readback();
        do_reset();
        to_val = 12'hA5C;
        step(1);
        chk("R3 readback", rb, 16'hA5CF);
    endtask

    task automatic t_scl_low();
        do_reset();
        scl = 0;
        step(15);
        chk("R6 before threshold", scl_flag, 0);
        step(1);
        chk("R6 at threshold", scl_flag, 1);
        chk("R5 idle event flag", evt_flag, 0);
    endtask

    task automatic t_event();
        do_reset();
        busy = 1;
        step(15);
        chk("R4 before threshold", evt_flag, 0);
        step(1);
        chk("R4 at threshold", evt_flag, 1);
        chk("R6 scl high", scl_flag, 0);
    endtask

    task automatic t_restart();
        do_reset();
        busy = 1;
        step(10);
        sda = 0;           // Start
        step(10);
        sda = 1;           // Stop
        step(16);
        chk("R4 stop restarted", evt_flag, 0);
        step(1);
        chk("R4 expiry after stop", evt_flag, 1);
        do_reset();
        busy = 1;
        for (int i = 0; i < 12; i++) begin
            scl = ~scl;
            step(10);
        end
        chk("R4 scl edges restart", evt_flag, 0);
        chk("R6 short low phases", scl_flag, 0);
    endtask

    task automatic t_idle();
        do_reset();
        step(200);
        chk("R5 idle bus", evt_flag, 0);
    endtask

    task automatic t_once();
        do_reset();
        busy = 1;
        step(16);
        chk("R8 first expiry", evt_flag, 1);
        flag_clr = 2'b01;
        step(1);
        flag_clr = 0;
        chk("R7 cleared", evt_flag, 0);
        step(50);
        chk("R8 no retrigger", evt_flag, 0);
        sda = 0;           // Start restarts the count
        step(16);
        chk("R8 rearm before", evt_flag, 0);
        step(1);
        chk("R8 rearm expiry", evt_flag, 1);
    endtask

    task automatic t_collide();
        do_reset();
        scl = 0;
        step(15);
        flag_clr = 2'b10;  // clear in the expiry cycle
        step(1);
        flag_clr = 0;
        chk("R7 expiry wins over clear", scl_flag, 1);
        step(3);
        chk("R7 sticky", scl_flag, 1);
        flag_clr = 2'b10;
        step(1);
        flag_clr = 0;
        chk("R7 clear alone", scl_flag, 0);
        step(20);
        chk("R8 scl no retrigger", scl_flag, 0);
    endtask

    task automatic t_disable();
        do_reset();
        busy = 1;
        step(10);
        en = 0;
        step(30);
        chk("R9 disabled no flag", evt_flag, 0);
        en = 1;
        step(15);
        chk("R9 restarted from zero", evt_flag, 0);
        step(1);
        chk("R9 full interval", evt_flag, 1);
        en = 0;
        step(5);
        chk("R9 flag kept", evt_flag, 1);
    endtask

    task automatic t_divider();
        do_reset();
        en = 0;
        div_val = 16'd2;
        to_val = 12'd1;
        busy = 1;
        step(3);
        en = 1;
        step(95);
        chk("R2 before divided threshold", evt_flag, 0);
        step(1);
        chk("R2 divided threshold", evt_flag, 1);
    endtask

    task automatic t_irq();
        do_reset();
        busy = 1;
        step(16);
        chk("R10 flag no enable", irq, 0);
        ie_set = 2'b01;
        step(1);
        ie_set = 0;
        chk("R10 enabled", irq, 1);
        ie_set = 2'b01; ie_clr = 2'b01;
        step(1);
        ie_set = 0; ie_clr = 0;
        chk("R10 clear wins", irq, 0);
        ie_set = 2'b11;
        step(1);
        ie_set = 0;
        chk("R10 re-enabled", irq, 1);
        flag_clr = 2'b01;
        step(1);
        flag_clr = 0;
        chk("R10 flag cleared", irq, 0);
        busy = 0;
        scl = 0;
        step(16);
        chk("R10 scl source", irq, 1);
        ie_clr = 2'b10;
        step(1);
        ie_clr = 0;
        chk("R10 scl disabled", irq, 0);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_scl_low();
        t_event();
        t_restart();
        t_idle();
        t_once();
        t_collide();
        t_disable();
        t_divider();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule